// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs a successive-approximation converter through a programmed list of conversion steps. A table of sixteen step entries is held in the block. Each entry selects the converter's positive input, its negative input and its positive reference, and sets how long the analog front end settles before sampling. When a sequence is triggered, the controller walks the steps in order from step 0. For each step it drives that step's selects and waits out the settling time. It then pulses a conversion start, waits the fixed conversion time, and emits the captured value together with the step number as a tagged result word.

Timing is measured in converter clocks, which are the system clock divided by a programmable power of two. A sequence can be started by a software strobe, by a rising edge on the pen-detect level, by either of the two, or it can repeat without any trigger. At the end of each sequence the controller passes through a one-cycle end state and raises a sticky end-of-sequence flag. The flag stays set until a command write clears it. The controller's state is reported one-hot, alongside the tag of the current step.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, state_o is 4'b0001, tag_o is 0, and eos_o, res_valid_o and conv_start_o are 0.
- R2: A write to address j (0..15) stores step entry j with this layout: [3:0] positive input select, [4] negative input select, [6:5] reference select, [11:7] settling time. While step j runs, inp_sel_o, inn_sel_o and ref_sel_o show that entry's fields.
- R3: Let D = 2^n, where n is bits [8:6] of the address-16 word. Step j lasts (S_j + 17)·D + 2 cycles. It spends S_j·D + 1 cycles in the settling state, so a settling time of 0 gives a single cycle there.
- R4: Entering the converting state produces a one-cycle pulse on conv_start_o. The converting state lasts 17·D + 1 cycles, and a sequence of N steps gives exactly N pulses.
- R5: A result leaves a step as a one-cycle res_valid_o pulse in the first cycle after the converting state. res_data_o carries the sampled conv_data_i in [15:6], zeros in [5:4] and the step tag in [3:0].
- R6: Bits [3:0] of the address-16 word hold N−1. A sequence runs steps 0..N−1 in order, giving N results, and N ranges from 1 to 16.
- R7: After the last step the controller spends one cycle in the end state (4'b1000), and eos_o is 1 from that cycle on. A write to address 17 with bit 0 set clears eos_o.
- R8: Bits [5:4] of the address-16 word select the trigger mode. Mode 0 starts a sequence on start_i or on a pen rise. Mode 1 starts only on a pen rise and mode 2 only on start_i. Mode 3 starts from idle with no trigger and goes from the end state straight back to step 0. A pen rise means pen_i is 1 in a cycle after a cycle in which it was 0.
- R9: A start_i pulse or pen rise that arrives while a sequence is running changes neither the results nor their timing.
- R10: The state_o encodings are: 4'b0001 idle, 4'b0010 settling, 4'b0100 converting, 4'b1000 end of sequence. tag_o is the current step and reads 0 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration address (0..15 steps, 16 sequence setup, 17 command) |
| cfg_wdata_i | input | 12 | Configuration write data |
| start_i | input | 1 | Software start strobe |
| pen_i | input | 1 | Pen-detect level |
| conv_data_i | input | 10 | Converter output value |
| inp_sel_o | output | 4 | Positive input select |
| inn_sel_o | output | 1 | Negative input select (ground or reference) |
| ref_sel_o | output | 2 | Positive reference select |
| conv_start_o | output | 1 | Conversion start pulse |
| res_valid_o | output | 1 | Result word valid |
| res_data_o | output | 16 | Tagged result word |
| state_o | output | 4 | One-hot controller state |
| tag_o | output | 4 | Current step tag |
| eos_o | output | 1 | Sticky end-of-sequence flag |

## Verification
The assertions assume that the step table and the sequence setup are not rewritten while a sequence is running, and that conv_data_i is a function of the select outputs. They also assume that start_i and pen_i are synchronous to clk_i. The bench writes configuration only while the controller is idle, with one exception: it rewrites the sequence setup mid-run to leave continuous mode, and that write keeps the step count and divider unchanged. Its converter model derives conv_data_i combinationally from the selects, so every captured value also confirms which entry drove the multiplexers.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_BANKS  = 16;
  localparam int TAG_W      = $clog2(NUM_BANKS);
  localparam int SEL_W      = 4;
  localparam int REF_W      = 2;
  localparam int SETTLE_W   = 5;
  localparam int DIV_W      = 3;
  localparam int DIVCNT_W   = (1 << DIV_W) - 1;
  localparam int RES_W      = 10;
  localparam int CONV_CLKS  = 17;
  localparam int PHASE_W    = (SETTLE_W > $clog2(CONV_CLKS + 1)) ? SETTLE_W : $clog2(CONV_CLKS + 1);
  localparam int CFG_W      = 12;
  localparam int ADDR_W     = 5;
  localparam int ADDR_SETUP = NUM_BANKS;
  localparam int ADDR_CMD   = NUM_BANKS + 1;
  localparam int WORD_W     = 16;
  localparam int PAD_W      = WORD_W - RES_W - TAG_W;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'b0001,
    ST_SETTLE = 4'b0010,
    ST_CONV   = 4'b0100,
    ST_EOS    = 4'b1000
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'd0,
    MODE_PEN  = 2'd1,
    MODE_SW   = 2'd2,
    MODE_CONT = 2'd3
  } start_mode_e;

  typedef struct packed {
    logic [SETTLE_W-1:0] settle;
    logic [REF_W-1:0]    ref_sel;
    logic                inn_sel;
    logic [SEL_W-1:0]    inp_sel;
  } bank_t;

  localparam int BANK_W = $bits(bank_t);
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic [TAG_W-1:0]  bank_idx_i,
  output bank_t             bank_o,
  output logic [TAG_W-1:0]  last_step_o,
  output start_mode_e       mode_o,
  output logic [DIV_W-1:0]  div_exp_o,
  output logic              eos_clr_o
);
  localparam int SETUP_W = TAG_W + 2 + DIV_W;

  bank_t              bank_q [NUM_BANKS];
  logic [SETUP_W-1:0] setup_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 bank_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))       bank_q[g] <= bank_t'(wdata_i[BANK_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   setup_q <= '0;
    else if (we_i && addr_i == ADDR_W'(ADDR_SETUP)) setup_q <= wdata_i[SETUP_W-1:0];
  end

  assign bank_o      = bank_q[bank_idx_i];
  assign last_step_o = setup_q[TAG_W-1:0];
  assign mode_o      = start_mode_e'(setup_q[TAG_W+1:TAG_W]);
  assign div_exp_o   = setup_q[SETUP_W-1:TAG_W+2];
  assign eos_clr_o   = we_i && addr_i == ADDR_W'(ADDR_CMD) && wdata_i[0];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[CFG_W-1:SETUP_W];
endmodule

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] exp_i,
  output logic             tick_o
);
  logic [DIVCNT_W-1:0] cnt_q;
  logic [DIVCNT_W-1:0] limit;

  // 2^exp - 1; exp at max wraps to all ones
  assign limit  = (DIVCNT_W'(1) << exp_i) - DIVCNT_W'(1);
  assign tick_o = (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIVCNT_W'(1);
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [TAG_W-1:0]    last_step_i,
  input  start_mode_e         mode_i,
  input  logic                tick_i,
  input  logic                sw_start_i,
  input  logic                pen_rise_i,
  input  logic                eos_clr_i,
  input  logic [RES_W-1:0]    conv_data_i,
  output seq_state_e          state_o,
  output logic [TAG_W-1:0]    step_o,
  output logic                div_clr_o,
  output logic                conv_start_o,
  output logic                res_valid_o,
  output logic [WORD_W-1:0]   res_data_o,
  output logic                eos_o
);
  seq_state_e         state_q, state_d;
  logic [TAG_W-1:0]   step_q, step_d;
  logic [PHASE_W-1:0] phase_q;
  logic               phase_clr;
  logic               trig;
  logic               conv_done;
  logic               conv_start_q, res_valid_q, eos_q;
  logic [WORD_W-1:0]  res_data_q;

  always_comb begin
    unique case (mode_i)
      MODE_ANY:  trig = sw_start_i | pen_rise_i;
      MODE_PEN:  trig = pen_rise_i;
      MODE_SW:   trig = sw_start_i;
      default:   trig = 1'b1;
    endcase
  end

  assign conv_done = (state_q == ST_CONV) && (phase_q == PHASE_W'(CONV_CLKS));

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    phase_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig) begin
          state_d   = ST_SETTLE;
          step_d    = '0;
          phase_clr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (phase_q == PHASE_W'(settle_i)) begin
          state_d   = ST_CONV;
          phase_clr = 1'b1;
        end
      end
      ST_CONV: begin
        if (conv_done) begin
          phase_clr = 1'b1;
          if (step_q == last_step_i) begin
            state_d = ST_EOS;
          end else begin
            state_d = ST_SETTLE;
            step_d  = step_q + TAG_W'(1);
          end
        end
      end
      default: begin
        step_d    = '0;
        phase_clr = 1'b1;
        state_d   = (mode_i == MODE_CONT) ? ST_SETTLE : ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      phase_q <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (phase_clr)
        phase_q <= '0;
      else if (tick_i && (state_q == ST_SETTLE || state_q == ST_CONV))
        phase_q <= phase_q + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_start_q <= 1'b0;
      res_valid_q  <= 1'b0;
      res_data_q   <= '0;
      eos_q        <= 1'b0;
    end else begin
      conv_start_q <= (state_d == ST_CONV) && (state_q != ST_CONV);
      res_valid_q  <= conv_done;
      if (conv_done) res_data_q <= {conv_data_i, {PAD_W{1'b0}}, step_q};
      if ((state_d == ST_EOS) && (state_q != ST_EOS)) eos_q <= 1'b1;
      else if (eos_clr_i)                              eos_q <= 1'b0;
    end
  end

  assign state_o      = state_q;
  assign step_o       = step_q;
  assign div_clr_o    = phase_clr;
  assign conv_start_o = conv_start_q;
  assign res_valid_o  = res_valid_q;
  assign res_data_o   = res_data_q;
  assign eos_o        = eos_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                start_i,
  input  logic                pen_i,
  input  logic [RES_W-1:0]    conv_data_i,
  output logic [SEL_W-1:0]    inp_sel_o,
  output logic                inn_sel_o,
  output logic [REF_W-1:0]    ref_sel_o,
  output logic                conv_start_o,
  output logic                res_valid_o,
  output logic [WORD_W-1:0]   res_data_o,
  output logic [3:0]          state_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic                eos_o
);
  bank_t            bank;
  logic [TAG_W-1:0] last_step;
  start_mode_e      mode;
  logic [DIV_W-1:0] div_exp;
  logic             eos_clr;
  logic             tick;
  logic             div_clr;
  logic             pen_q;
  logic             pen_rise;
  seq_state_e       state;
  logic [TAG_W-1:0] step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pen_q <= 1'b0;
    else         pen_q <= pen_i;
  end
  assign pen_rise = pen_i & ~pen_q;

  adc_seq_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .bank_idx_i  (step),
    .bank_o      (bank),
    .last_step_o (last_step),
    .mode_o      (mode),
    .div_exp_o   (div_exp),
    .eos_clr_o   (eos_clr)
  );

  adc_seq_clkdiv u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (div_clr),
    .exp_i  (div_exp),
    .tick_o (tick)
  );

  adc_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .settle_i     (bank.settle),
    .last_step_i  (last_step),
    .mode_i       (mode),
    .tick_i       (tick),
    .sw_start_i   (start_i),
    .pen_rise_i   (pen_rise),
    .eos_clr_i    (eos_clr),
    .conv_data_i  (conv_data_i),
    .state_o      (state),
    .step_o       (step),
    .div_clr_o    (div_clr),
    .conv_start_o (conv_start_o),
    .res_valid_o  (res_valid_o),
    .res_data_o   (res_data_o),
    .eos_o        (eos_o)
  );

  assign inp_sel_o = bank.inp_sel;
  assign inn_sel_o = bank.inn_sel;
  assign ref_sel_o = bank.ref_sel;
  assign state_o   = state;
  assign tag_o     = step;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic [SEL_W-1:0]  inp_sel_o,
  input logic              conv_start_o,
  input logic              res_valid_o,
  input logic [WORD_W-1:0] res_data_o,
  input logic [3:0]        state_o,
  input logic [TAG_W-1:0]  tag_o,
  input logic              eos_o
);
  logic clr_wr;
  assign clr_wr = cfg_we_i && cfg_addr_i == ADDR_W'(ADDR_CMD) && cfg_wdata_i[0];

  p_onehot_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1);

  p_idle_tag_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE) |-> (tag_o == '0));

  p_start_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_start_on_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (state_o == ST_CONV && $past(state_o) == ST_SETTLE));

  p_result_after_conv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ($past(state_o) == ST_CONV && res_data_o[TAG_W-1:0] == $past(tag_o)));

  p_result_pad_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_data_o[WORD_W-RES_W-1:TAG_W] == '0));

  p_sel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_CONV && $past(state_o) == ST_CONV) |-> $stable(inp_sel_o));

  p_settle_same_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SETTLE && $past(state_o) == ST_SETTLE) |-> $stable(tag_o));

  p_eos_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_EOS) |-> eos_o);

  p_eos_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_o && !clr_wr) |=> eos_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .inp_sel_o    (inp_sel_o),
  .conv_start_o (conv_start_o),
  .res_valid_o  (res_valid_o),
  .res_data_o   (res_data_o),
  .state_o      (state_o),
  .tag_o        (tag_o),
  .eos_o        (eos_o)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_addr_i = '0;
  logic [11:0] cfg_wdata_i = '0;
  logic        start_i = 1'b0;
  logic        pen_i = 1'b0;
  logic [9:0]  conv_data_i;
  logic [3:0]  inp_sel_o;
  logic        inn_sel_o;
  logic [1:0]  ref_sel_o;
  logic        conv_start_o;
  logic        res_valid_o;
  logic [15:0] res_data_o;
  logic [3:0]  state_o;
  logic [3:0]  tag_o;
  logic        eos_o;

  int vec_cnt = 0;
  int err_cnt = 0;
  int cyc = 0;
  int got_n = 0;
  int cs_n = 0;
  int          got_cyc  [64];
  logic [15:0] got_data [64];

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // converter model: value is a fixed function of the selects
  assign conv_data_i = {inn_sel_o, ref_sel_o, inp_sel_o, 3'b011} ^ 10'h2A5;

  always @(negedge clk_i) begin
    if (res_valid_o && got_n < 64) begin
      got_cyc[got_n]  = cyc;
      got_data[got_n] = res_data_o;
      got_n++;
    end
    if (conv_start_o) cs_n++;
  end

  adc_seq_ctrl dut_i (.*);

  function automatic int f_inp(int j, int c); return (j * 5 + c) & 15; endfunction
  function automatic int f_inn(int j, int c); return (j + c) & 1; endfunction
  function automatic int f_ref(int j, int c); return (j * 3 + c) & 3; endfunction
  function automatic int f_set(int j, int c); return (j * 7 + c * 3) % 32; endfunction

  function automatic logic [15:0] exp_word(int j, int c);
    logic [9:0] v;
    v = {f_inn(j, c) != 0, 2'(f_ref(j, c)), 4'(f_inp(j, c)), 3'b011} ^ 10'h2A5;
    return {v, 2'b00, 4'(j)};
  endfunction

  function automatic int step_len(int j, int c, int dexp);
    return (f_set(j, c) + 17) * (1 << dexp) + 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cfg_write(int addr, int data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 5'(addr); cfg_wdata_i = 12'(data);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic program_all(int c, int n, int dexp, int mode);
    for (int j = 0; j < 16; j++)
      cfg_write(j, (f_set(j, c) << 7) | (f_ref(j, c) << 5) | (f_inn(j, c) << 4) | f_inp(j, c));
    cfg_write(16, (dexp << 6) | (mode << 4) | (n - 1));
  endtask

  task automatic run_seq(int c, int n, int dexp, bit use_pen, bit inject);
    int d;
    int total;
    int c0;
    int cum;
    d = 1 << dexp;
    total = 0;
    for (int j = 0; j < n; j++) total += step_len(j, c, dexp);
    got_n = 0; cs_n = 0;
    @(negedge clk_i);
    c0 = cyc;
    if (use_pen) pen_i = 1'b1; else start_i = 1'b1;
    @(negedge clk_i);
    pen_i = 1'b0; start_i = 1'b0;
    chk(state_o == 4'b0010 && tag_o == 4'd0, "R10 settle entry", {state_o, tag_o}, 8'h20);
    while (cyc < c0 + 3 + total) begin
      if (inject && cyc == c0 + 9) begin start_i = 1'b1; pen_i = 1'b1; end
      else begin start_i = 1'b0; pen_i = 1'b0; end
      @(negedge clk_i);
      if (cyc == c0 + 2 + f_set(0, c) * d)
        chk(state_o == 4'b0100 && conv_start_o, "R4 conv start", {state_o, 3'b0, conv_start_o}, 8'h41);
      if (cyc == c0 + 1 + total)
        chk(state_o == 4'b1000 && eos_o, "R7 end state", {state_o, 3'b0, eos_o}, 8'h81);
    end
    start_i = 1'b0; pen_i = 1'b0;
    chk(got_n == n, "R6 result count", got_n, n);
    chk(cs_n == n, "R4 start pulses", cs_n, n);
    cum = 0;
    for (int k = 0; k < n && k < got_n; k++) begin
      cum += step_len(k, c, dexp);
      chk(got_cyc[k] == c0 + 1 + cum, "R3 step timing", got_cyc[k] - c0, 1 + cum);
      chk(got_data[k][15:6] == exp_word(k, c)[15:6], "R2 selected value", got_data[k][15:6], exp_word(k, c)[15:6]);
      chk(got_data[k][5:0] == exp_word(k, c)[5:0], "R5 tag field", got_data[k][5:0], exp_word(k, c)[5:0]);
    end
    chk(state_o == 4'b0001 && tag_o == 4'd0, "R10 back to idle", {state_o, tag_o}, 8'h10);
    chk(eos_o == 1'b1, "R7 flag held", eos_o, 1);
    cfg_write(17, 1);
    chk(eos_o == 1'b0, "R7 flag cleared", eos_o, 0);
  endtask

  task automatic expect_no_start(bit use_pen, string req);
    got_n = 0; cs_n = 0;
    @(negedge clk_i);
    if (use_pen) pen_i = 1'b1; else start_i = 1'b1;
    @(negedge clk_i);
    pen_i = 1'b0; start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(state_o == 4'b0001 && got_n == 0 && cs_n == 0, req, {state_o, 4'(got_n), 4'(cs_n)}, 12'h100);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    err_cnt++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    int c0;
    int total;
    int cum;
    int nn;
    repeat (3) @(negedge clk_i);
    chk(state_o == 4'b0001 && tag_o == 0 && !eos_o && !res_valid_o && !conv_start_o,
        "R1 reset state", {state_o, tag_o, eos_o, res_valid_o, conv_start_o}, 11'h080);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(state_o == 4'b0001 && tag_o == 0 && !eos_o, "R1 after release", {state_o, tag_o}, 8'h10);

    // R3 R6: sweep divider and step count, software trigger
    for (int dexp = 0; dexp < 3; dexp++) begin
      for (int i = 0; i < 3; i++) begin
        nn = (i == 0) ? 1 : (i == 1) ? 5 : 16;
        program_all(dexp * 3 + i, nn, dexp, 2);
        run_seq(dexp * 3 + i, nn, dexp, 1'b0, 1'b0);
      end
    end

    // R8 pen-only mode
    program_all(11, 3, 1, 1);
    expect_no_start(1'b0, "R8 start ignored in pen mode");
    run_seq(11, 3, 1, 1'b1, 1'b0);

    // R8 software-only mode
    program_all(12, 2, 0, 2);
    expect_no_start(1'b1, "R8 pen ignored in software mode");

    // R9: requests during a run, either-trigger mode
    program_all(13, 4, 1, 0);
    run_seq(13, 4, 1, 1'b1, 1'b1);
    run_seq(13, 4, 1, 1'b0, 1'b1);

    // R8 continuous mode
    program_all(14, 2, 0, 2);
    got_n = 0;
    cfg_write(16, (0 << 6) | (3 << 4) | 1);
    c0 = cyc;
    total = step_len(0, 14, 0) + step_len(1, 14, 0);
    for (int w = 0; w < 2000 && got_n < 6; w++) @(negedge clk_i);
    chk(got_n >= 6, "R8 continuous results", got_n, 6);
    for (int k = 0; k < 6 && k < got_n; k++) begin
      cum = (k % 2 == 0) ? step_len(0, 14, 0) : total;
      chk(got_cyc[k] == c0 + 1 + (k / 2) * (total + 1) + cum, "R8 continuous timing",
          got_cyc[k] - c0, 1 + (k / 2) * (total + 1) + cum);
      chk(got_data[k] == exp_word(k % 2, 14), "R8 continuous data", got_data[k], exp_word(k % 2, 14));
    end
    cfg_write(16, (0 << 6) | (2 << 4) | 1);
    repeat (200) @(negedge clk_i);
    chk(state_o == 4'b0001 && (got_n % 2) == 0, "R8 continuous stop", {state_o, 4'(got_n % 2)}, 8'h10);
    chk(eos_o == 1'b1, "R7 flag after continuous", eos_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule